// File: doc/BRIEF.md
# Streaming Systematic Binary Encoder

This block multiplies a binary message by a systematic generator matrix whose identity part is implied and whose redundancy part arrives as a stream. A pulse on `start` captures a K-bit message and clears the parity accumulator. The redundancy matrix then streams in over a valid/ready word port. Its lines arrive one after another, with line 0 first, and each line takes a fixed number of words. No part of the matrix is stored. Each incoming word is gated by the message bit that selects its line and is XOR-folded into the matching slice of the accumulator, so encoding keeps pace with the transfer.

Each line is padded up to a whole number of words, and the padding is discarded on entry. When the last word of the last line is taken, `done_o` rises. The codeword then appears as the parity bits followed by the message, and both stay fixed until the next `start`. The small instance used for testing has 6 lines, 10 parity bits and 8-bit words. The default instance has 1498 lines, 550 parity bits and 64-bit words, which gives 9 words per line.

Top module: `sys_stream_encoder`

## Requirements
- R1: After reset, `done_o` is 0, `key_ready` is 0 and `code_o` is all zeros.
- R2: A `start` pulse captures `msg_i` and clears the parity. In the next cycle `done_o` is 0, `key_ready` is 1, the parity field of `code_o` is zero and its message field equals the captured message.
- R3: A word is consumed only in a cycle where `key_valid` and `key_ready` are both 1. `key_ready` is 0 before the first `start` and while done, so words offered in those cycles leave `code_o` unchanged.
- R4: Word j of line i is XORed into parity bits [j*WORD_W +: WORD_W] only when message bit i is 1 (message bit 0 selects line 0, the first line sent). Words advance j first and then i.
- R5: Bits of a word that lie at parity positions of PAR_BITS or above (the padding) never reach the parity.
- R6: `done_o` rises in the cycle after the last word of the last line is consumed, and `code_o` already includes that word.
- R7: `code_o` = {parity[PAR_BITS-1:0], message[K-1:0]}, with the parity in the upper bits and the message in the lower K bits.
- R8: Idle cycles between words (`key_valid` low) do not change the result.
- R9: While done and without `start`, `done_o` stays 1 and `code_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture message, clear parity, begin a run |
| msg_i | input | K | Message to encode |
| key_valid | input | 1 | Key word present |
| key_data | input | WORD_W | Key word, line-major, word-minor |
| key_ready | output | 1 | Encoder accepts key words |
| code_o | output | PAR_BITS+K | Codeword {parity, message} |
| done_o | output | 1 | Codeword complete |

## Verification
The tightest cycle is the one where the final word of the final line is consumed. In that same edge the last accumulation into the parity and the change of state to done both take effect. The bench streams every case up to that word and samples at the following falling edge. There, `done_o` must be high, and the codeword must equal a matrix-vector product over GF(2) computed in the bench that includes the final word. Cases with idle gaps between words and cases where garbage words are held valid around the run show whether the last word is dropped, counted twice or absorbed outside the run.

// File: rtl/enc_pkg.sv
package enc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } enc_state_e;
endpackage

// File: rtl/enc_walk.sv
// Tracks the word index within a line and the line index across the key.
module enc_walk #(
    parameter int K   = 1498,
    parameter int WPL = 9,
    localparam int W_W = (WPL > 1) ? $clog2(WPL) : 1,
    localparam int L_W = (K > 1) ? $clog2(K) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    output logic [W_W-1:0] widx,
    output logic [L_W-1:0] line,
    output logic           last_word
);
    typedef struct packed {
        logic [W_W-1:0] widx;
        logic [L_W-1:0] line;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (clear) begin
            w_d = '0;
        end else if (step) begin
            if (w_q.widx == W_W'(WPL - 1)) begin
                w_d.widx = '0;
                w_d.line = (w_q.line == L_W'(K - 1)) ? '0 : w_q.line + 1'b1;
            end else begin
                w_d.widx = w_q.widx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign widx      = w_q.widx;
    assign line      = w_q.line;
    assign last_word = (w_q.widx == W_W'(WPL - 1)) && (w_q.line == L_W'(K - 1));

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(widx) && $stable(line)));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (widx != W_W'(WPL - 1))) |=>
        (widx == W_W'($past(widx) + 1'b1)) && $stable(line));
endmodule

// File: rtl/enc_gate.sv
// One AND gate per word bit: message-bit select plus padding mask.
module enc_gate #(
    parameter int WORD_W   = 64,
    parameter int PAR_BITS = 550,
    parameter int W_W      = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic              sel,
    input  logic [W_W-1:0]    widx,
    output logic [WORD_W-1:0] gated
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        logic keep;
        assign keep     = ((int'(widx) * WORD_W + b) < PAR_BITS);
        assign gated[b] = word[b] & sel & keep;
    end
endmodule

// File: rtl/sys_stream_encoder.sv
module sys_stream_encoder
    import enc_pkg::*;
#(
    parameter int K        = 1498,
    parameter int PAR_BITS = 550,
    parameter int WORD_W   = 64,
    localparam int CODE_W  = PAR_BITS + K
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [K-1:0]      msg_i,
    input  logic              key_valid,
    input  logic [WORD_W-1:0] key_data,
    output logic              key_ready,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);
    localparam int WPL   = (PAR_BITS + WORD_W - 1) / WORD_W;
    localparam int ACC_W = WPL * WORD_W;
    localparam int W_W   = (WPL > 1) ? $clog2(WPL) : 1;
    localparam int L_W   = (K > 1) ? $clog2(K) : 1;

    typedef struct packed {
        enc_state_e       st;
        logic [K-1:0]     msg;
        logic [ACC_W-1:0] acc;
    } regs_t;

    regs_t r_d, r_q;

    logic              take;
    logic [W_W-1:0]    widx;
    logic [L_W-1:0]    line;
    logic              last_word;
    logic [WORD_W-1:0] gated;

    assign key_ready = (r_q.st == ST_RUN);
    assign take      = key_valid && key_ready && !start;

    enc_walk #(.K(K), .WPL(WPL)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .step      (take),
        .widx      (widx),
        .line      (line),
        .last_word (last_word)
    );

    enc_gate #(.WORD_W(WORD_W), .PAR_BITS(PAR_BITS), .W_W(W_W)) u_gate (
        .word  (key_data),
        .sel   (r_q.msg[line]),
        .widx  (widx),
        .gated (gated)
    );

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.st  = ST_RUN;
            r_d.msg = msg_i;
            r_d.acc = '0;
        end else if (take) begin
            for (int s = 0; s < WPL; s++) begin
                if (widx == W_W'(s))
                    r_d.acc[s*WORD_W +: WORD_W] = r_q.acc[s*WORD_W +: WORD_W] ^ gated;
            end
            if (last_word) r_d.st = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.msg <= '0;
            r_q.acc <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o = {r_q.acc[PAR_BITS-1:0], r_q.msg};
    assign done_o = (r_q.st == ST_DONE);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done_o && key_ready && (code_o[CODE_W-1:K] == '0) &&
                   (code_o[K-1:0] == $past(msg_i))));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(key_valid && key_ready));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && $stable(code_o)));

    // R5
    if (ACC_W > PAR_BITS) begin : g_pad_chk
        pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (r_q.acc[ACC_W-1:PAR_BITS] == '0));
    end
endmodule

// File: tb/tb_sys_stream_encoder.sv
module tb_sys_stream_encoder;
    localparam int K      = 6;
    localparam int PAR    = 10;
    localparam int WW     = 8;
    localparam int WPL    = (PAR + WW - 1) / WW;
    localparam int CODE_W = PAR + K;
    localparam int NCASE  = 8;

    // message, stall flag, zero-rows flag
    localparam logic [K-1:0] MSG_T   [NCASE] = '{6'b000000, 6'b111111, 6'b000001, 6'b100000,
                                                 6'b101010, 6'b010101, 6'b110011, 6'b111111};
    localparam logic         STALL_T [NCASE] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic         ZERO_T  [NCASE] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    logic clk = 0, rst_n = 0, start = 0, key_valid = 0;
    logic [K-1:0] msg_i = '0;
    logic [WW-1:0] key_data = '0;
    logic key_ready, done_o;
    logic [CODE_W-1:0] code_o;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sys_stream_encoder #(.K(K), .PAR_BITS(PAR), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .msg_i(msg_i),
        .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
        .code_o(code_o), .done_o(done_o));

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PAR-1:0] row(input int c, input int i);
        logic [31:0] v;
        if (ZERO_T[c]) return '0;
        v = c * 32'd2654435 + i * 32'd40503 + 32'd977;
        v = v ^ (v >> 7);
        return v[PAR-1:0] ^ v[PAR+11:12];
    endfunction

    function automatic logic [CODE_W-1:0] expect_code(input int c);
        logic [PAR-1:0] p = '0;
        for (int i = 0; i < K; i++)
            if (MSG_T[c][i]) p ^= row(c, i);
        return {p, MSG_T[c]};
    endfunction

    // padding bits forced to ones so that leakage would show (R5)
    function automatic logic [WW-1:0] word_of(input int c, input int i, input int j);
        logic [WPL*WW-1:0] padded = '1;
        padded[PAR-1:0] = row(c, i);
        return padded[j*WW +: WW];
    endfunction

    task automatic run_case(input int c);
        logic [CODE_W-1:0] exp, held;
        bit early;
        exp = expect_code(c);
        @(negedge clk);
        key_valid = 1; key_data = 8'hA5;
        check(!key_ready, "R3 ready low outside run", 64'(key_ready), 64'd0);
        @(negedge clk);
        start = 1; msg_i = MSG_T[c];
        @(negedge clk);
        start = 0; key_valid = 0;
        check(!done_o && key_ready, "R2 run entered", {62'd0, done_o, key_ready}, 64'd1);
        check(code_o == {{PAR{1'b0}}, MSG_T[c]}, "R2 parity cleared", 64'(code_o), 64'({{PAR{1'b0}}, MSG_T[c]}));
        early = 0;
        for (int i = 0; i < K; i++) begin
            for (int j = 0; j < WPL; j++) begin
                if (STALL_T[c]) begin
                    key_valid = 0; key_data = 8'hFF;
                    @(negedge clk);
                end
                if (done_o) early = 1;
                key_valid = 1; key_data = word_of(c, i, j);
                @(negedge clk);
            end
        end
        key_data = 8'h3C;
        check(!early, "R6 done not early", 64'(early), 64'd0);
        check(done_o, "R6 done after last word", 64'(done_o), 64'd1);
        check(code_o == exp, STALL_T[c] ? "R8 R4 R7 codeword stalled" : "R4 R7 codeword", 64'(code_o), 64'(exp));
        held = code_o;
        repeat (3) @(negedge clk);
        check(done_o && code_o == held, "R9 R3 hold while done", 64'(code_o), 64'(held));
        key_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!done_o && !key_ready && code_o == '0, "R1 reset state",
              64'({done_o, key_ready, code_o}), 64'd0);
        rst_n = 1;
        for (int c = 0; c < NCASE; c++) run_case(c);
        // R5 explicit: all rows zero, padding ones, all bits selected
        check(expect_code(NCASE - 1) == {{PAR{1'b0}}, 6'b111111}, "R5 reference parity zero",
              64'(expect_code(NCASE - 1)), 64'({{PAR{1'b0}}, 6'b111111}));
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule